// File: doc/BRIEF.md
# External 16-bit Memory Access Sequencer

This block sits between an on-chip requester and an external memory device with a 16-bit data path. It accepts one read or write request at a time. A request can be 8, 16 or 32 bits wide. The block turns it into one or two external accesses and drives the chip enable, output enable, write enable, address-valid, two active-low byte-lane strobes, the halfword address and the write data. Read data is gathered back into a 32-bit result. A request the device cannot serve is answered with an error and causes no memory activity.

Each request selects one of two timing modes:

- **Asynchronous mode** uses a fixed address-setup phase of `ADDSET` cycles. It is followed by a data phase of `DATSET` cycles, and the output enable or write enable is low only during the data phase.
- **Synchronous mode** uses a memory clock that runs at the system clock divided by 2, 3 or 4. Control strobes go low together with a falling edge of that clock and go high together with a rising edge.

Every output is decoded from registers, so it changes only on the rising edge of the system clock.

The sequencer has nine states:

- `ST_IDLE` waits for a request.
- `ST_REJECT` answers an illegal request.
- `ST_A_SETUP` and `ST_A_DATA` are the asynchronous address phase and data phase.
- `ST_S_ALIGN` waits for a falling memory-clock edge.
- `ST_S_ADDR` is the synchronous address phase.
- `ST_S_LAT` is the gap between the synchronous address and data phases.
- `ST_S_DATA` is the synchronous data phase.
- `ST_DONE` answers a completed request.

The transitions are:

- `ST_IDLE` goes to `ST_REJECT` on an illegal request, to `ST_A_SETUP` on an asynchronous request, and to `ST_S_ALIGN` on a synchronous request.
- `ST_A_SETUP` goes to `ST_A_DATA` when the setup count runs out.
- `ST_A_DATA` goes back to `ST_A_SETUP` for the upper half of a 32-bit request, otherwise to `ST_DONE`.
- `ST_S_ALIGN` goes to `ST_S_ADDR` on a falling edge of the memory clock.
- `ST_S_ADDR` goes to `ST_S_LAT` on a rising edge.
- `ST_S_LAT` goes to `ST_S_DATA` on a falling edge.
- `ST_S_DATA` goes to `ST_S_ALIGN` on a rising edge when the upper half is still owed, otherwise to `ST_DONE`.
- `ST_REJECT` and `ST_DONE` both return to `ST_IDLE`.

Top module: `xmem16_seq`

## Requirements
- R1: After reset, `mem_ce_n`, `mem_oe_n`, `mem_we_n` and `mem_adv_n` are 1, `mem_bl_n` is 2'b11, and `req_ready` and `req_err` are 0.
- R2: A request is rejected if its size code is 3, or if it is a synchronous 8-bit read, or if it is an asynchronous read with `req_page` set. A rejected request produces a one-cycle `req_ready` with `req_err`=1, and `mem_ce_n` stays high.
- R3: In asynchronous mode, each 16-bit access holds `mem_adv_n` low for `ADDSET` cycles. It then holds `mem_oe_n` (read) or `mem_we_n` (write) low for `DATSET` cycles. `mem_ce_n` is low for `ADDSET+DATSET` cycles per access. The output enable and the write enable are never low together.
- R4: A 32-bit request (size code 2) performs two accesses. They use halfword addresses `req_addr>>1` and `req_addr>>1 + 1` (byte address plus 2), in that order. `req_ready` comes only after the second access.
- R5: The size codes are 0 = 8-bit, 1 = 16-bit and 2 = 32-bit. While `mem_ce_n` is low, `mem_bl_n` is 2'b10 for an 8-bit access at an even byte address and 2'b01 at an odd one; bit 0 is the low byte lane. It is 2'b00 for 16-bit and 32-bit accesses. While `mem_ce_n` is high, `mem_bl_n` is 2'b11.
- R6: During a write, `mem_dq_out` carries `{wdata[7:0],wdata[7:0]}` for 8-bit, `wdata[15:0]` for 16-bit, and `wdata[15:0]` then `wdata[31:16]` for 32-bit.
- R7: On completion of a read, `req_rdata` holds the values below; the unused upper bits are zero.
  - 8-bit: the addressed byte of the halfword read.
  - 16-bit: the halfword read.
  - 32-bit: `{second halfword, first halfword}`.
- R8: In synchronous mode, a falling edge of any of `mem_ce_n`, `mem_oe_n`, `mem_we_n` or `mem_adv_n` occurs only in the same cycle as a falling edge of `mem_clk`.
- R9: In synchronous mode, a rising edge of any of `mem_ce_n`, `mem_oe_n`, `mem_we_n` or `mem_adv_n` occurs only in the same cycle as a rising edge of `mem_clk`.
- R10: `mem_clk` has a period of D system cycles and is high for floor(D/2) of them. D is `cfg_div` limited to the range 2 to 4.
- R11: With D from R10, let L = D - floor(D/2) and H = floor(D/2). In synchronous mode each access holds `mem_adv_n` low for L cycles and `mem_oe_n`/`mem_we_n` low for L cycles. `mem_ce_n` is low for 2L+H cycles.
- R12: `req_ready` is high for exactly one cycle per request. While a request is in progress, `req_valid` is ignored, so a request held until `req_ready` produces exactly one set of accesses.
- R13: `req_page` has no effect on writes or on synchronous reads: such requests complete with `req_err`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_div | input | 3 | Memory clock divider, limited to 2..4 |
| req_valid | input | 1 | Request present; held until `req_ready` |
| req_write | input | 1 | 1 = write, 0 = read |
| req_size | input | 2 | 0 = 8-bit, 1 = 16-bit, 2 = 32-bit, 3 = illegal |
| req_addr | input | ADDR_W | Byte address |
| req_wdata | input | 32 | Write data |
| req_sync | input | 1 | 1 = synchronous mode |
| req_page | input | 1 | Page-mode read requested |
| req_ready | output | 1 | One-cycle completion pulse |
| req_err | output | 1 | Request rejected, valid with `req_ready` |
| req_rdata | output | 32 | Read result, valid with `req_ready` |
| mem_clk | output | 1 | Divided memory clock |
| mem_addr | output | ADDR_W-1 | Halfword address |
| mem_ce_n | output | 1 | Chip enable, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_adv_n | output | 1 | Address valid, active low |
| mem_bl_n | output | 2 | Byte-lane strobes, active low, bit 0 = low byte |
| mem_dq_out | output | 16 | Write data to memory |
| mem_dq_oe | output | 1 | Drive enable for `mem_dq_out` |
| mem_dq_in | input | 16 | Read data from memory |

## Verification
The following are checked on every cycle:

- Edge alignment in synchronous mode: a strobe falls only with a falling memory-clock edge and rises only with a rising one.
- The byte lanes stay idle whenever the chip enable is high.
- An 8-bit access enables exactly one lane.
- The output enable and the write enable are never low together.
- `req_ready` is a single-cycle pulse, and errors are reported only with it.

Only the bench's scenarios can show the rest:

- the arithmetic results, meaning the address of each half, the placement of write data and the assembled read data;
- the phase lengths for each divider value;
- the divider limits;
- which combinations of mode, size and page flag are rejected.

// File: rtl/xm_pkg.sv
package xm_pkg;
    localparam int MEM_W = 16;
    localparam int BUS_W = 32;

    localparam logic [1:0] SZ_BYTE = 2'd0;
    localparam logic [1:0] SZ_HALF = 2'd1;
    localparam logic [1:0] SZ_WORD = 2'd2;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_REJECT,
        ST_A_SETUP,
        ST_A_DATA,
        ST_S_ALIGN,
        ST_S_ADDR,
        ST_S_LAT,
        ST_S_DATA,
        ST_DONE
    } seq_state_e;
endpackage

// File: rtl/xm_clkgen.sv
module xm_clkgen #(
    parameter int DIV_MIN = 2,
    parameter int DIV_MAX = 4,
    parameter int CFG_W   = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CFG_W-1:0] cfg_div,
    output logic             mem_clk,
    output logic             rise_en,
    output logic             fall_en
);
    localparam int CNT_W = $clog2(DIV_MAX);

    logic [CFG_W-1:0] div_eff;
    logic [CFG_W-1:0] hi_len;
    logic [CNT_W-1:0] cnt_q;

    // Limit the divider to the supported range.
    always_comb begin
        if (cfg_div < CFG_W'(DIV_MIN)) begin
            div_eff = CFG_W'(DIV_MIN);
        end else if (cfg_div > CFG_W'(DIV_MAX)) begin
            div_eff = CFG_W'(DIV_MAX);
        end else begin
            div_eff = cfg_div;
        end
    end

    assign hi_len = div_eff >> 1;

    // Enables mark the cycle before the memory clock edge, so that the
    // edge and any state change that follows it share one system edge.
    assign rise_en = (CFG_W'(cnt_q) == div_eff - CFG_W'(1));
    assign fall_en = (CFG_W'(cnt_q) == hi_len - CFG_W'(1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q   <= '0;
            mem_clk <= 1'b1;
        end else begin
            if (rise_en) begin
                cnt_q   <= '0;
                mem_clk <= 1'b1;
            end else begin
                cnt_q <= cnt_q + CNT_W'(1);
                if (fall_en) begin
                    mem_clk <= 1'b0;
                end
            end
        end
    end
endmodule

// File: rtl/xm_reqcheck.sv
module xm_reqcheck
    import xm_pkg::*;
(
    input  logic       write,
    input  logic [1:0] size,
    input  logic       sync,
    input  logic       page,
    input  logic       addr_lsb,
    output logic       illegal,
    output logic [1:0] lanes,
    output logic       two_halves
);
    always_comb begin
        illegal = 1'b0;
        if (size == 2'd3) begin
            illegal = 1'b1;
        end
        if (sync && !write && size == SZ_BYTE) begin
            illegal = 1'b1;
        end
        if (!sync && !write && page) begin
            illegal = 1'b1;
        end
    end

    // lanes is active high here; bit 0 is the low byte lane.
    always_comb begin
        if (size == SZ_BYTE) begin
            lanes = addr_lsb ? 2'b10 : 2'b01;
        end else begin
            lanes = 2'b11;
        end
    end

    assign two_halves = (size == SZ_WORD);
endmodule

// File: rtl/xm_seq_fsm.sv
module xm_seq_fsm
    import xm_pkg::*;
#(
    parameter int ADDSET = 2,
    parameter int DATSET = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic req_valid,
    input  logic illegal,
    input  logic sync_in,
    input  logic write_q,
    input  logic two_q,
    input  logic rise_en,
    input  logic fall_en,
    output logic idle,
    output logic half,
    output logic cap,
    output logic done,
    output logic err,
    output logic ce_n,
    output logic oe_n,
    output logic we_n,
    output logic adv_n,
    output logic dq_oe
);
    localparam int PH_MAX = (ADDSET > DATSET) ? ADDSET : DATSET;
    localparam int CNT_W  = $clog2(PH_MAX + 1);
    localparam logic [CNT_W-1:0] SET_LOAD = CNT_W'(ADDSET - 1);
    localparam logic [CNT_W-1:0] DAT_LOAD = CNT_W'(DATSET - 1);

    seq_state_e       state_q, state_n;
    logic [CNT_W-1:0] cnt_q, cnt_n;
    logic             half_q, half_n;

    always_comb begin
        state_n = state_q;
        cnt_n   = cnt_q;
        half_n  = half_q;
        unique case (state_q)
            ST_IDLE: begin
                if (req_valid) begin
                    half_n = 1'b0;
                    if (illegal) begin
                        state_n = ST_REJECT;
                    end else if (sync_in) begin
                        state_n = ST_S_ALIGN;
                    end else begin
                        state_n = ST_A_SETUP;
                        cnt_n   = SET_LOAD;
                    end
                end
            end
            ST_REJECT: state_n = ST_IDLE;
            ST_A_SETUP: begin
                if (cnt_q == '0) begin
                    state_n = ST_A_DATA;
                    cnt_n   = DAT_LOAD;
                end else begin
                    cnt_n = cnt_q - CNT_W'(1);
                end
            end
            ST_A_DATA: begin
                if (cnt_q == '0) begin
                    if (two_q && !half_q) begin
                        state_n = ST_A_SETUP;
                        cnt_n   = SET_LOAD;
                        half_n  = 1'b1;
                    end else begin
                        state_n = ST_DONE;
                    end
                end else begin
                    cnt_n = cnt_q - CNT_W'(1);
                end
            end
            ST_S_ALIGN: if (fall_en) state_n = ST_S_ADDR;
            ST_S_ADDR:  if (rise_en) state_n = ST_S_LAT;
            ST_S_LAT:   if (fall_en) state_n = ST_S_DATA;
            ST_S_DATA: begin
                if (rise_en) begin
                    if (two_q && !half_q) begin
                        state_n = ST_S_ALIGN;
                        half_n  = 1'b1;
                    end else begin
                        state_n = ST_DONE;
                    end
                end
            end
            ST_DONE: state_n = ST_IDLE;
            default: state_n = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            half_q  <= 1'b0;
        end else begin
            state_q <= state_n;
            cnt_q   <= cnt_n;
            half_q  <= half_n;
        end
    end

    assign half = half_q;

    always_comb begin
        idle  = 1'b0;
        cap   = 1'b0;
        done  = 1'b0;
        err   = 1'b0;
        ce_n  = 1'b1;
        oe_n  = 1'b1;
        we_n  = 1'b1;
        adv_n = 1'b1;
        dq_oe = 1'b0;
        unique case (state_q)
            ST_IDLE: idle = 1'b1;
            ST_REJECT: begin
                done = 1'b1;
                err  = 1'b1;
            end
            ST_A_SETUP, ST_S_ADDR: begin
                ce_n  = 1'b0;
                adv_n = 1'b0;
            end
            ST_A_DATA: begin
                ce_n  = 1'b0;
                oe_n  = write_q;
                we_n  = !write_q;
                dq_oe = write_q;
                cap   = (cnt_q == '0);
            end
            ST_S_LAT: ce_n = 1'b0;
            ST_S_DATA: begin
                ce_n  = 1'b0;
                oe_n  = write_q;
                we_n  = !write_q;
                dq_oe = write_q;
                cap   = rise_en;
            end
            ST_DONE: done = 1'b1;
            default: ;
        endcase
    end
endmodule

// File: rtl/xmem16_seq.sv
module xmem16_seq
    import xm_pkg::*;
#(
    parameter int ADDR_W  = 16,
    parameter int ADDSET  = 2,
    parameter int DATSET  = 3,
    parameter int DIV_MIN = 2,
    parameter int DIV_MAX = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [2:0]        cfg_div,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [1:0]        req_size,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [31:0]       req_wdata,
    input  logic              req_sync,
    input  logic              req_page,
    output logic              req_ready,
    output logic              req_err,
    output logic [31:0]       req_rdata,
    output logic              mem_clk,
    output logic [ADDR_W-2:0] mem_addr,
    output logic              mem_ce_n,
    output logic              mem_oe_n,
    output logic              mem_we_n,
    output logic              mem_adv_n,
    output logic [1:0]        mem_bl_n,
    output logic [15:0]       mem_dq_out,
    output logic              mem_dq_oe,
    input  logic [15:0]       mem_dq_in
);
    logic              rise_en, fall_en;
    logic              illegal, two_halves;
    logic [1:0]        lanes;
    logic              idle, half, cap;

    logic              write_q, sync_q, two_q;
    logic [1:0]        size_q, lanes_q;
    logic [ADDR_W-1:0] addr_q;
    logic [BUS_W-1:0]  wdata_q;
    logic [MEM_W-1:0]  rlo_q, rhi_q;
    logic              accept;

    xm_clkgen #(
        .DIV_MIN (DIV_MIN),
        .DIV_MAX (DIV_MAX),
        .CFG_W   (3)
    ) u_clkgen (
        .clk     (clk),
        .rst_n   (rst_n),
        .cfg_div (cfg_div),
        .mem_clk (mem_clk),
        .rise_en (rise_en),
        .fall_en (fall_en)
    );

    xm_reqcheck u_check (
        .write      (req_write),
        .size       (req_size),
        .sync       (req_sync),
        .page       (req_page),
        .addr_lsb   (req_addr[0]),
        .illegal    (illegal),
        .lanes      (lanes),
        .two_halves (two_halves)
    );

    xm_seq_fsm #(
        .ADDSET (ADDSET),
        .DATSET (DATSET)
    ) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .illegal   (illegal),
        .sync_in   (req_sync),
        .write_q   (write_q),
        .two_q     (two_q),
        .rise_en   (rise_en),
        .fall_en   (fall_en),
        .idle      (idle),
        .half      (half),
        .cap       (cap),
        .done      (req_ready),
        .err       (req_err),
        .ce_n      (mem_ce_n),
        .oe_n      (mem_oe_n),
        .we_n      (mem_we_n),
        .adv_n     (mem_adv_n),
        .dq_oe     (mem_dq_oe)
    );

    assign accept = idle && req_valid;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            write_q <= 1'b0;
            sync_q  <= 1'b0;
            two_q   <= 1'b0;
            size_q  <= SZ_HALF;
            lanes_q <= 2'b00;
            addr_q  <= '0;
            wdata_q <= '0;
        end else if (accept) begin
            write_q <= req_write;
            sync_q  <= req_sync;
            two_q   <= two_halves;
            size_q  <= req_size;
            lanes_q <= lanes;
            addr_q  <= req_addr;
            wdata_q <= req_wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rlo_q <= '0;
            rhi_q <= '0;
        end else if (cap && !write_q) begin
            if (half) begin
                rhi_q <= mem_dq_in;
            end else begin
                rlo_q <= mem_dq_in;
            end
        end
    end

    assign mem_addr = addr_q[ADDR_W-1:1] + {{(ADDR_W-2){1'b0}}, half};
    assign mem_bl_n = mem_ce_n ? 2'b11 : ~lanes_q;

    always_comb begin
        if (half) begin
            mem_dq_out = wdata_q[31:16];
        end else if (size_q == SZ_BYTE) begin
            mem_dq_out = {wdata_q[7:0], wdata_q[7:0]};
        end else begin
            mem_dq_out = wdata_q[15:0];
        end
    end

    always_comb begin
        unique case (size_q)
            SZ_BYTE: req_rdata = {24'h0, addr_q[0] ? rlo_q[15:8] : rlo_q[7:0]};
            SZ_HALF: req_rdata = {16'h0, rlo_q};
            default: req_rdata = {rhi_q, rlo_q};
        endcase
    end
endmodule

// File: rtl/xm_seq_checker.sv
module xm_seq_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       sync_q,
    input logic [1:0] size_q,
    input logic       mem_clk,
    input logic       mem_ce_n,
    input logic       mem_oe_n,
    input logic       mem_we_n,
    input logic       mem_adv_n,
    input logic [1:0] mem_bl_n,
    input logic       req_ready,
    input logic       req_err
);
    assert_strobe_fall_aligned_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (sync_q && ($fell(mem_ce_n) || $fell(mem_oe_n) || $fell(mem_we_n) || $fell(mem_adv_n)))
        |-> $fell(mem_clk));

    assert_strobe_rise_aligned_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (sync_q && ($rose(mem_ce_n) || $rose(mem_oe_n) || $rose(mem_we_n) || $rose(mem_adv_n)))
        |-> $rose(mem_clk));

    assert_lanes_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
        mem_ce_n |-> (mem_bl_n == 2'b11));

    assert_byte_single_lane_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_ce_n && size_q == 2'd0) |-> ($countones(mem_bl_n) == 1));

    assert_no_oe_we_overlap_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_oe_n |-> mem_we_n);

    assert_ready_single_R12: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |=> !req_ready);

    assert_err_with_ready_R2: assert property (@(posedge clk) disable iff (!rst_n)
        req_err |-> (req_ready && mem_ce_n));
endmodule

bind xmem16_seq xm_seq_checker u_seq_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .sync_q    (sync_q),
    .size_q    (size_q),
    .mem_clk   (mem_clk),
    .mem_ce_n  (mem_ce_n),
    .mem_oe_n  (mem_oe_n),
    .mem_we_n  (mem_we_n),
    .mem_adv_n (mem_adv_n),
    .mem_bl_n  (mem_bl_n),
    .req_ready (req_ready),
    .req_err   (req_err)
);

// File: tb/test_xmem16_seq.sv
module test_xmem16_seq;
    localparam int AW     = 16;
    localparam int ADDSET = 2;
    localparam int DATSET = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [2:0]    cfg_div = 3'd2;
    logic          req_valid = 1'b0;
    logic          req_write = 1'b0;
    logic [1:0]    req_size = 2'd0;
    logic [AW-1:0] req_addr = '0;
    logic [31:0]   req_wdata = '0;
    logic          req_sync = 1'b0;
    logic          req_page = 1'b0;
    logic          req_ready, req_err;
    logic [31:0]   req_rdata;
    logic          mem_clk;
    logic [AW-2:0] mem_addr;
    logic          mem_ce_n, mem_oe_n, mem_we_n, mem_adv_n, mem_dq_oe;
    logic [1:0]    mem_bl_n;
    logic [15:0]   mem_dq_out, mem_dq_in;

    always #2 clk = ~clk;

    xmem16_seq #(.ADDR_W(AW), .ADDSET(ADDSET), .DATSET(DATSET)) i_xmem16_seq (
        .clk(clk), .rst_n(rst_n), .cfg_div(cfg_div),
        .req_valid(req_valid), .req_write(req_write), .req_size(req_size),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_sync(req_sync),
        .req_page(req_page), .req_ready(req_ready), .req_err(req_err),
        .req_rdata(req_rdata), .mem_clk(mem_clk), .mem_addr(mem_addr),
        .mem_ce_n(mem_ce_n), .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n),
        .mem_adv_n(mem_adv_n), .mem_bl_n(mem_bl_n), .mem_dq_out(mem_dq_out),
        .mem_dq_oe(mem_dq_oe), .mem_dq_in(mem_dq_in)
    );

    function automatic logic [15:0] pat(input logic [AW-2:0] a);
        return (16'({1'b0, a}) * 16'h03B1) ^ 16'hA5C3;
    endfunction

    assign mem_dq_in = (!mem_ce_n && !mem_oe_n) ? pat(mem_addr) : 16'h0000;

    int n_checks = 0;
    int n_fail   = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Per-request observation of the memory side, sampled at negedge.
    bit          mon_sync = 1'b0;
    int          ce_cnt, oe_cnt, we_cnt, adv_cnt, nacc, nwr;
    logic [AW-2:0] acc_addr [4];
    logic [1:0]  acc_bl [4];
    logic [15:0] wr_data [4];
    logic        p_ce = 1'b1, p_oe = 1'b1, p_we = 1'b1, p_adv = 1'b1, p_clk = 1'b1;

    always @(negedge clk) begin
        if (rst_n) begin
            if (!mem_ce_n)  ce_cnt++;
            if (!mem_oe_n)  oe_cnt++;
            if (!mem_we_n)  we_cnt++;
            if (!mem_adv_n) adv_cnt++;
            if (!mem_adv_n && p_adv) begin
                if (nacc < 4) begin
                    acc_addr[nacc] = mem_addr;
                    acc_bl[nacc]   = mem_bl_n;
                end
                nacc++;
            end
            if (!mem_we_n && p_we) begin
                if (nwr < 4) wr_data[nwr] = mem_dq_out;
                nwr++;
            end
            if (mon_sync) begin
                if ((p_ce && !mem_ce_n) || (p_oe && !mem_oe_n) ||
                    (p_we && !mem_we_n) || (p_adv && !mem_adv_n))
                    chk(p_clk && !mem_clk, "R8", "strobe fall vs mem_clk fall",
                        {p_clk, mem_clk}, 2'b10);
                if ((!p_ce && mem_ce_n) || (!p_oe && mem_oe_n) ||
                    (!p_we && mem_we_n) || (!p_adv && mem_adv_n))
                    chk(!p_clk && mem_clk, "R9", "strobe rise vs mem_clk rise",
                        {p_clk, mem_clk}, 2'b01);
            end
        end
        p_ce = mem_ce_n; p_oe = mem_oe_n; p_we = mem_we_n;
        p_adv = mem_adv_n; p_clk = mem_clk;
    end

    int cyc = 0;
    always @(posedge clk) begin
        cyc++;
        if (cyc > 190000) begin
            n_checks++;
            n_fail++;
            $display("FAIL R12 watchdog expired: actual %0d expected %0d", cyc, 190000);
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    task automatic do_req(input bit w, input logic [1:0] sz, input logic [AW-1:0] a,
                          input logic [31:0] wd, input bit s, input bit pg, input int dv);
        int t;
        bit got_err;
        logic [31:0] got_rd;
        int halves, hh, ll, dph, aph, cph;
        bit illg;
        logic [AW-2:0] h;
        logic [1:0] exp_bl;
        logic [15:0] exp_w;
        logic [31:0] exp_rd;
        @(negedge clk);
        ce_cnt = 0; oe_cnt = 0; we_cnt = 0; adv_cnt = 0; nacc = 0; nwr = 0;
        mon_sync  = s;
        req_write = w; req_size = sz; req_addr = a; req_wdata = wd;
        req_sync  = s; req_page = pg; req_valid = 1'b1;
        t = 0;
        do begin
            @(negedge clk);
            t++;
        end while (!req_ready && t < 400);
        got_err = req_err;
        got_rd  = req_rdata;
        req_valid = 1'b0;
        chk(t < 400, "R12", "request completes", t, 400);
        @(negedge clk);
        chk(!req_ready, "R12", "ready one cycle", req_ready, 0);

        illg   = (sz == 2'd3) || (s && !w && sz == 2'd0) || (!s && !w && pg);
        halves = (sz == 2'd2) ? 2 : 1;
        hh = dv / 2;
        ll = dv - hh;
        h  = a[AW-1:1];
        if (illg) begin
            chk(got_err, "R2", "error flag", got_err, 1);
            chk(ce_cnt == 0, "R2", "no chip enable", ce_cnt, 0);
        end else begin
            chk(!got_err, pg ? "R13" : "R2", "no error", got_err, 0);
            chk(nacc == halves, "R12", "access count", nacc, halves);
            exp_bl = (sz == 2'd0) ? (a[0] ? 2'b01 : 2'b10) : 2'b00;
            for (int i = 0; i < halves && i < nacc; i++) begin
                chk(acc_addr[i] == h + (AW-1)'(i), "R4", "half address",
                    acc_addr[i], h + (AW-1)'(i));
                chk(acc_bl[i] == exp_bl, "R5", "byte lanes", acc_bl[i], exp_bl);
            end
            if (s) begin
                aph = ll; dph = ll; cph = 2 * ll + hh;
            end else begin
                aph = ADDSET; dph = DATSET; cph = ADDSET + DATSET;
            end
            chk(adv_cnt == aph * halves, s ? "R11" : "R3", "adv low cycles", adv_cnt, aph * halves);
            chk(ce_cnt == cph * halves, s ? "R11" : "R3", "ce low cycles", ce_cnt, cph * halves);
            chk(oe_cnt == (w ? 0 : dph * halves), s ? "R11" : "R3", "oe low cycles",
                oe_cnt, w ? 0 : dph * halves);
            chk(we_cnt == (w ? dph * halves : 0), s ? "R11" : "R3", "we low cycles",
                we_cnt, w ? dph * halves : 0);
            if (w) begin
                chk(nwr == halves, "R4", "write strobes", nwr, halves);
                for (int i = 0; i < halves && i < nwr; i++) begin
                    if (sz == 2'd0)      exp_w = {wd[7:0], wd[7:0]};
                    else if (i == 1)     exp_w = wd[31:16];
                    else                 exp_w = wd[15:0];
                    chk(wr_data[i] == exp_w, "R6", "write data", wr_data[i], exp_w);
                end
            end else begin
                if (sz == 2'd0)      exp_rd = {24'h0, a[0] ? pat(h)[15:8] : pat(h)[7:0]};
                else if (sz == 2'd1) exp_rd = {16'h0, pat(h)};
                else                 exp_rd = {pat(h + (AW-1)'(1)), pat(h)};
                chk(got_rd == exp_rd, "R7", "read data", got_rd, exp_rd);
            end
        end
    endtask

    task automatic measure_clk(input logic [2:0] cfg, input int exp_div);
        logic pv;
        int g, per, hi;
        cfg_div = cfg;
        repeat (12) @(negedge clk);
        pv = mem_clk;
        g  = 0;
        do begin
            pv = mem_clk;
            @(negedge clk);
            g++;
        end while (!(mem_clk && !pv) && g < 20);
        per = 0;
        hi  = 0;
        do begin
            if (mem_clk) hi++;
            per++;
            pv = mem_clk;
            @(negedge clk);
        end while (!(mem_clk && !pv) && per < 20);
        chk(per == exp_div, "R10", "mem_clk period", per, exp_div);
        chk(hi == exp_div / 2, "R10", "mem_clk high time", hi, exp_div / 2);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(mem_ce_n && mem_oe_n && mem_we_n && mem_adv_n, "R1", "strobes idle in reset",
            {mem_ce_n, mem_oe_n, mem_we_n, mem_adv_n}, 4'hF);
        rst_n = 1'b1;
        @(negedge clk);
        chk(mem_ce_n && mem_oe_n && mem_we_n && mem_adv_n, "R1", "strobes idle after reset",
            {mem_ce_n, mem_oe_n, mem_we_n, mem_adv_n}, 4'hF);
        chk(mem_bl_n == 2'b11, "R1", "lanes idle", mem_bl_n, 2'b11);
        chk(!req_ready && !req_err, "R1", "response idle", {req_ready, req_err}, 0);

        measure_clk(3'd0, 2);
        measure_clk(3'd2, 2);
        measure_clk(3'd3, 3);
        measure_clk(3'd4, 4);
        measure_clk(3'd7, 4);

        for (int dv = 2; dv <= 4; dv++) begin
            cfg_div = 3'(dv);
            repeat (8) @(negedge clk);
            for (int s = 0; s < 2; s++)
                for (int w = 0; w < 2; w++)
                    for (int sz = 0; sz < 4; sz++)
                        for (int off = 0; off < 4; off++)
                            for (int pg = 0; pg < 2; pg++) begin
                                logic [AW-1:0] a;
                                a = 16'h2000 + AW'(dv * 64 + s * 32 + w * 16) + AW'(off);
                                if (sz == 1) a[0] = 1'b0;
                                if (sz == 2) a[1:0] = 2'b00;
                                do_req(w[0], 2'(sz), a, {a ^ 16'h5A5A, ~a}, s[0], pg[0], dv);
                            end
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule